// File: doc/BRIEF.md
# Strain Alert and Status Monitor

This block watches one channel of calibrated strain samples, the signed micro-strain values that the scaling stage produces, each qualified by a valid strobe. It keeps the lowest and the highest value seen since the host last asked for a fresh capture. It compares every sample against two independent alert tiers, and each tier has its own signed low and high limit. It also takes the fault flags raised by the converter and by the built-in test logic.

Every condition is reported in two forms. The realtime form follows the present state. The latched form records that the condition has happened and holds it until the host clears it. A single summary bit gathers the fault conditions. Each status can drive an interrupt request, which is either a one-cycle pulse or a held level.

The host writes limits, interrupt enables, trigger types, latch clears and commands through a small write-only register port:
- Address 0 holds the tier 1 low limit, and address 1 holds the tier 1 high limit.
- Address 2 holds the tier 2 low limit, and address 3 holds the tier 2 high limit.
- Address 4 holds the interrupt enable mask.
- Address 5 holds the trigger-type mask, where 1 selects level and 0 selects edge.
- Address 6 takes a write-one-to-clear mask for the latches.
- Address 7 is the command register. Bit 0 is the channel status enable, and writing 1 to bit 1 resets the min/max capture.

Status bit positions:
- Bit 0: BIT failure.
- Bit 1: open bridge.
- Bit 2: converter error.
- Bit 3: missing reference.
- Bit 4: tier 1 high alert.
- Bit 5: tier 1 low alert.
- Bit 6: tier 2 high alert.
- Bit 7: tier 2 low alert.

Top module: `strain_status_monitor`

## Requirements
- R1: One clock edge after a valid sample, tier 1 realtime high (bit 4) is 1 exactly when the sample is strictly greater than the tier 1 high limit. Tier 1 realtime low (bit 5) is 1 exactly when the sample is strictly less than the tier 1 low limit. Both comparisons are signed. Both bits hold between valid samples. Writes to the limits act from the next edge. After reset the limits are the most negative (low) and the most positive (high) code.
- R2: Tier 2 (bits 6 and 7, addresses 2 and 3) behaves the same way, independently of tier 1.
- R3: A latched bit sets on the edge after its realtime bit is 1 while the channel is enabled. It stays set until a write of 1 to that bit position at address 6. When a clear and a set meet in the same cycle, the set wins.
- R4: Realtime BIT (bit 0) is the OR of the loop-test and amplifier-test failure inputs, registered one edge.
- R5: Realtime bits 1, 2 and 3 follow the open-bridge, converter-error and missing-reference inputs, registered one edge.
- R6: The realtime summary is the OR of realtime bits 0 to 3. The latched summary is the OR of latched bits 0 to 3.
- R7: Min/max capture works as follows:
  - After reset, and after a write of 1 to bit 1 at address 7, the capture is empty (valid flag 0).
  - The next valid sample loads both the minimum and the maximum.
  - Later valid samples widen them with a signed compare.
  - A sample that arrives in the same cycle as the reset command is discarded.
- R8: With the trigger bit at 1 (level), an interrupt line is high while its enable bit and its latched bit are both 1.
- R9: With the trigger bit at 0 (edge), an enabled interrupt line pulses high for one cycle on the rising edge of its latched bit.
- R10: The channel status enable (address 7, bit 0) is 0 after reset. While it is 0, all realtime, latched, summary and interrupt outputs read 0, and no latch sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | STRAIN_W | Register write data |
| sampleValid | input | 1 | Strain sample qualifier |
| sample | input | STRAIN_W | Signed strain sample |
| loopFail | input | 1 | Converter loop test failed |
| ampFail | input | 1 | Front-end amplifier test failed |
| openBridge | input | 1 | Bridge open or disconnected |
| adcErr | input | 1 | Converter error |
| refMissing | input | 1 | Converter reference absent |
| rtStatus | output | 8 | Realtime status bits |
| latStatus | output | 8 | Latched status bits |
| summaryRt | output | 1 | Realtime fault summary |
| summaryLat | output | 1 | Latched fault summary |
| irq | output | 8 | Per-status interrupt requests |
| minStrain | output | STRAIN_W | Lowest captured sample |
| maxStrain | output | STRAIN_W | Highest captured sample |
| minMaxValid | output | 1 | Capture holds at least one sample |

## Verification
The bench aims at samples that equal a limit exactly. A design using a non-strict compare would raise an alert there. It also feeds negative samples against positive limits, where an unsigned compare would flag the wrong side. It writes a clear while the condition is still present, which exposes a clear-over-set priority as a latched bit that drops for a cycle. The min/max reset is followed at once by samples far from zero, so a design that preloads extreme constants or keeps stale values reports the wrong extremes. Edge-mode interrupts are checked to last exactly one cycle, level-mode interrupts to follow the latch, and a disabled channel to show nothing at all.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int NTIER  = 2;
  localparam int NFAULT = 4;
  localparam int NST    = NFAULT + 2 * NTIER;
  localparam int AW     = 3;

  localparam logic [AW-1:0] ADDR_IEN   = 3'd4;
  localparam logic [AW-1:0] ADDR_TRIG  = 3'd5;
  localparam logic [AW-1:0] ADDR_CLEAR = 3'd6;
  localparam logic [AW-1:0] ADDR_CMD   = 3'd7;

  // strobes from control to datapath, valid for a single cycle
  typedef struct packed {
    logic [NST-1:0] clrMask;
    logic           mmReset;
  } sgmStrobe_t;
endpackage

// File: rtl/sgm_ctrl.sv
module sgm_ctrl
  import sgm_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [AW-1:0]              wrAddr,
  input  logic [W-1:0]               wrData,
  output logic [NTIER-1:0][W-1:0]    thrLo,
  output logic [NTIER-1:0][W-1:0]    thrHi,
  output logic [NST-1:0]             ienMask,
  output logic [NST-1:0]             trigLevel,
  output logic                       chanEn,
  output sgmStrobe_t                 strobe
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  for (genvar t = 0; t < NTIER; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrLo[t] <= MOST_NEG;
        thrHi[t] <= MOST_POS;
      end else if (wrEn) begin
        if (wrAddr == AW'(2 * t))     thrLo[t] <= wrData;
        if (wrAddr == AW'(2 * t + 1)) thrHi[t] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienMask   <= '0;
      trigLevel <= '0;
      chanEn    <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_IEN)  ienMask   <= wrData[NST-1:0];
      if (wrAddr == ADDR_TRIG) trigLevel <= wrData[NST-1:0];
      if (wrAddr == ADDR_CMD)  chanEn    <= wrData[0];
    end
  end

  always_comb begin
    strobe.clrMask = (wrEn && wrAddr == ADDR_CLEAR) ? wrData[NST-1:0] : '0;
    strobe.mmReset = wrEn && wrAddr == ADDR_CMD && wrData[1];
  end
endmodule

// File: rtl/sgm_datapath.sv
module sgm_datapath
  import sgm_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [W-1:0]             sample,
  input  logic                     loopFail,
  input  logic                     ampFail,
  input  logic                     openBridge,
  input  logic                     adcErr,
  input  logic                     refMissing,
  input  logic [NTIER-1:0][W-1:0]  thrLo,
  input  logic [NTIER-1:0][W-1:0]  thrHi,
  input  logic [NST-1:0]           ienMask,
  input  logic [NST-1:0]           trigLevel,
  input  logic                     chanEn,
  input  sgmStrobe_t               strobe,
  output logic [NST-1:0]           rtStatus,
  output logic [NST-1:0]           latStatus,
  output logic                     summaryRt,
  output logic                     summaryLat,
  output logic [NST-1:0]           irq,
  output logic [W-1:0]             minStrain,
  output logic [W-1:0]             maxStrain,
  output logic                     minMaxValid
);
  logic [NTIER-1:0] hiHit, loHit;
  logic [NST-1:0]   rtRaw, rtNext, latReg, latPrev;
  logic [NST-1:0]   enMask;

  for (genvar t = 0; t < NTIER; t++) begin : g_cmp
    assign hiHit[t] = $signed(sample) > $signed(thrHi[t]);
    assign loHit[t] = $signed(sample) < $signed(thrLo[t]);
  end

  always_comb begin
    rtNext    = rtRaw;
    rtNext[0] = loopFail | ampFail;
    rtNext[1] = openBridge;
    rtNext[2] = adcErr;
    rtNext[3] = refMissing;
    if (sampleValid) begin
      for (int t = 0; t < NTIER; t++) begin
        rtNext[NFAULT + 2 * t]     = hiHit[t];
        rtNext[NFAULT + 2 * t + 1] = loHit[t];
      end
    end
  end

  assign enMask = {NST{chanEn}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtRaw   <= '0;
      latReg  <= '0;
      latPrev <= '0;
    end else begin
      rtRaw   <= rtNext;
      latReg  <= (latReg & ~strobe.clrMask) | (rtRaw & enMask);
      latPrev <= latReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      minStrain   <= '0;
      maxStrain   <= '0;
      minMaxValid <= 1'b0;
    end else if (strobe.mmReset) begin
      minMaxValid <= 1'b0;
    end else if (sampleValid) begin
      minMaxValid <= 1'b1;
      if (!minMaxValid || $signed(sample) < $signed(minStrain)) minStrain <= sample;
      if (!minMaxValid || $signed(sample) > $signed(maxStrain)) maxStrain <= sample;
    end
  end

  assign rtStatus   = rtRaw & enMask;
  assign latStatus  = latReg & enMask;
  assign summaryRt  = chanEn & (|rtRaw[NFAULT-1:0]);
  assign summaryLat = chanEn & (|latReg[NFAULT-1:0]);
  assign irq        = enMask & ienMask & latReg & (trigLevel | ~latPrev);
endmodule

// File: rtl/strain_status_monitor.sv
module strain_status_monitor
  import sgm_pkg::*;
#(
  parameter int STRAIN_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [STRAIN_W-1:0] wrData,
  input  logic                sampleValid,
  input  logic [STRAIN_W-1:0] sample,
  input  logic                loopFail,
  input  logic                ampFail,
  input  logic                openBridge,
  input  logic                adcErr,
  input  logic                refMissing,
  output logic [7:0]          rtStatus,
  output logic [7:0]          latStatus,
  output logic                summaryRt,
  output logic                summaryLat,
  output logic [7:0]          irq,
  output logic [STRAIN_W-1:0] minStrain,
  output logic [STRAIN_W-1:0] maxStrain,
  output logic                minMaxValid
);
  logic [NTIER-1:0][STRAIN_W-1:0] thrLo, thrHi;
  logic [NST-1:0] ienMask, trigLevel;
  logic           chanEn;
  sgmStrobe_t     strobe;

  sgm_ctrl #(.W(STRAIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .thrLo(thrLo), .thrHi(thrHi), .ienMask(ienMask), .trigLevel(trigLevel),
    .chanEn(chanEn), .strobe(strobe)
  );

  sgm_datapath #(.W(STRAIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sample(sample),
    .loopFail(loopFail), .ampFail(ampFail), .openBridge(openBridge),
    .adcErr(adcErr), .refMissing(refMissing), .thrLo(thrLo), .thrHi(thrHi),
    .ienMask(ienMask), .trigLevel(trigLevel), .chanEn(chanEn), .strobe(strobe),
    .rtStatus(rtStatus), .latStatus(latStatus), .summaryRt(summaryRt),
    .summaryLat(summaryLat), .irq(irq), .minStrain(minStrain),
    .maxStrain(maxStrain), .minMaxValid(minMaxValid)
  );
endmodule

// File: rtl/sgm_checker.sv
module sgm_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [2:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic         loopFail,
  input logic         ampFail,
  input logic         chanEn,
  input logic [7:0]   rtStatus,
  input logic [7:0]   latStatus,
  input logic         summaryRt,
  input logic [7:0]   irq,
  input logic [W-1:0] minStrain,
  input logic [W-1:0] maxStrain,
  input logic         minMaxValid
);
  a_r7_min_le_max: assert property (@(posedge clk) disable iff (!rstN)
    minMaxValid |-> $signed(minStrain) <= $signed(maxStrain));

  a_r4_bit_or: assert property (@(posedge clk) disable iff (!rstN)
    (loopFail || ampFail) |=> (rtStatus[0] == chanEn));

  a_r6_summary_rt: assert property (@(posedge clk) disable iff (!rstN)
    summaryRt == (|rtStatus[3:0]));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> (rtStatus == 8'd0 && latStatus == 8'd0 && irq == 8'd0));

  for (genvar i = 0; i < 8; i++) begin : g_bit
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (latStatus[i] && !(wrEn && wrAddr == 3'd6 && wrData[i]))
        |=> (latStatus[i] || !chanEn));
    a_r3_sets_from_rt: assert property (@(posedge clk) disable iff (!rstN)
      rtStatus[i] |=> (latStatus[i] || !chanEn));
    a_r8_irq_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
      irq[i] |-> latStatus[i]);
  end
endmodule

bind strain_status_monitor sgm_checker #(.W(STRAIN_W)) u_sgm_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .loopFail(loopFail), .ampFail(ampFail), .chanEn(chanEn),
  .rtStatus(rtStatus), .latStatus(latStatus), .summaryRt(summaryRt),
  .irq(irq), .minStrain(minStrain), .maxStrain(maxStrain),
  .minMaxValid(minMaxValid)
);

// File: tb/test_strain_status_monitor.sv
module test_strain_status_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic sv = 1'b0;
  logic signed [W-1:0] smp = '0;
  logic loopF = 0, ampF = 0, openB = 0, adE = 0, refM = 0;
  logic [7:0] rtStatus, latStatus, irq;
  logic summaryRt, summaryLat, minMaxValid;
  logic [W-1:0] minStrain, maxStrain;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic signed [W-1:0] mLo [2];
  logic signed [W-1:0] mHi [2];
  logic signed [W-1:0] mMin, mMax;
  logic [7:0] mIen, mTrig, mRt, mLat, mLatPrev;
  logic mEn, mMmv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strain_status_monitor #(.STRAIN_W(W)) i_strain_status_monitor (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleValid(sv), .sample(smp), .loopFail(loopF), .ampFail(ampF),
    .openBridge(openB), .adcErr(adE), .refMissing(refM),
    .rtStatus(rtStatus), .latStatus(latStatus), .summaryRt(summaryRt),
    .summaryLat(summaryLat), .irq(irq), .minStrain(minStrain),
    .maxStrain(maxStrain), .minMaxValid(minMaxValid)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    mLo[0] = {1'b1, {(W-1){1'b0}}}; mLo[1] = mLo[0];
    mHi[0] = {1'b0, {(W-1){1'b1}}}; mHi[1] = mHi[0];
    mMin = '0; mMax = '0; mIen = '0; mTrig = '0; mRt = '0;
    mLat = '0; mLatPrev = '0; mEn = 0; mMmv = 0;
  endtask

  task automatic checkAll();
    logic [7:0] eRt, eLat, eIrq;
    eRt  = mEn ? mRt : 8'd0;
    eLat = mEn ? mLat : 8'd0;
    eIrq = (mEn ? 8'hFF : 8'h00) & mIen & mLat & (mTrig | ~mLatPrev);
    chk("R1 tier1 realtime", 64'(rtStatus[5:4]), 64'(eRt[5:4]));
    chk("R2 tier2 realtime", 64'(rtStatus[7:6]), 64'(eRt[7:6]));
    chk("R4 BIT realtime", 64'(rtStatus[0]), 64'(eRt[0]));
    chk("R5 fault realtime", 64'(rtStatus[3:1]), 64'(eRt[3:1]));
    chk("R3 latched", 64'(latStatus), 64'(eLat));
    chk("R6 summary", {62'd0, summaryRt, summaryLat}, {62'd0, |eRt[3:0], |eLat[3:0]});
    chk("R7 min/max", {15'd0, minMaxValid, minStrain, maxStrain},
        {15'd0, mMmv, (mMmv || minMaxValid) ? {mMin, mMax} : {minStrain, maxStrain}});
    chk("R8 level irq", 64'(irq & mTrig), 64'(eIrq & mTrig));
    chk("R9 edge irq", 64'(irq & ~mTrig), 64'(eIrq & ~mTrig));
    if (!mEn) chk("R10 disabled", {40'd0, rtStatus, latStatus, irq}, 64'd0);
  endtask

  // one clock: the inputs set before the call are taken at the edge
  task automatic step();
    logic [7:0] clr, nRt, nLat;
    logic mmr;
    @(posedge clk);
    #1;
    clr  = (wrEn && wrAddr == 3'd6) ? wrData[7:0] : 8'd0;
    mmr  = wrEn && wrAddr == 3'd7 && wrData[1];
    nRt  = mRt;
    nRt[0] = loopF | ampF; nRt[1] = openB; nRt[2] = adE; nRt[3] = refM;
    if (sv) begin
      for (int t = 0; t < 2; t++) begin
        nRt[4 + 2 * t] = smp > mHi[t];
        nRt[5 + 2 * t] = smp < mLo[t];
      end
    end
    nLat = (mLat & ~clr) | (mEn ? mRt : 8'd0);
    mLatPrev = mLat; mLat = nLat; mRt = nRt;
    if (mmr) mMmv = 0;
    else if (sv) begin
      if (!mMmv) begin mMin = smp; mMax = smp; mMmv = 1; end
      else begin
        if (smp < mMin) mMin = smp;
        if (smp > mMax) mMax = smp;
      end
    end
    if (wrEn) begin
      case (wrAddr)
        3'd0: mLo[0] = wrData;
        3'd1: mHi[0] = wrData;
        3'd2: mLo[1] = wrData;
        3'd3: mHi[1] = wrData;
        3'd4: mIen = wrData[7:0];
        3'd5: mTrig = wrData[7:0];
        3'd7: mEn = wrData[0];
        default: ;
      endcase
    end
    #1;
    checkAll();
  endtask

  task automatic idle();
    wrEn = 0; sv = 0;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    idle(); wrEn = 1; wrAddr = a; wrData = W'(d); step(); wrEn = 0;
  endtask

  task automatic samp(input int v, input int n);
    idle(); sv = 1; smp = W'(v);
    for (int k = 0; k < n; k++) step();
    sv = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // reset state: everything zero, capture empty, channel disabled (R10, R7)
    chk("R10 reset outputs", {40'd0, rtStatus, latStatus, irq}, 64'd0);
    chk("R7 reset capture", 64'(minMaxValid), 64'd0);
    // disabled channel with a fault present must stay silent (R10)
    loopF = 1; step(); step(); loopF = 0;
    wr(3'd7, 1);
    wr(3'd0, -100); wr(3'd1, 100); wr(3'd2, -500); wr(3'd3, 500);
    wr(3'd4, 255); wr(3'd5, 0);
    // R1 boundaries: equal to the limit does not alert, one past does
    samp(100, 2); samp(101, 2); samp(600, 2);
    samp(-100, 2); samp(-101, 2); samp(-501, 2);
    // R3 set beats clear: condition still present while clearing
    idle(); sv = 1; smp = W'(600); wrEn = 1; wrAddr = 3'd6; wrData = W'(8'hFF);
    step(); step(); idle(); step();
    samp(0, 2); wr(3'd6, 255); step();
    // R4 each test input alone, R5 faults
    loopF = 1; step(); step(); loopF = 0; ampF = 1; step(); ampF = 0;
    openB = 1; adE = 1; step(); openB = 0; adE = 0; refM = 1; step(); refM = 0; step();
    // R7 reset then far-off samples
    wr(3'd7, 3); samp(-7000, 1); samp(-6000, 1); samp(9000, 1);
    // same-cycle reset and sample: sample dropped
    idle(); sv = 1; smp = W'(-8); wrEn = 1; wrAddr = 3'd7; wrData = W'(3); step(); idle();
    samp(42, 1);
    // R8 level mode
    wr(3'd5, 255); wr(3'd6, 255); samp(700, 3); wr(3'd6, 255); samp(0, 2); wr(3'd6, 255);
    // R9 edge mode back
    wr(3'd5, 0); samp(800, 3); samp(0, 1); wr(3'd6, 255); step();
    // random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      idle();
      sv = ($urandom_range(0, 2) != 0);
      smp = W'($signed($urandom_range(0, 2400)) - 1200);
      loopF = ($urandom_range(0, 15) == 0); ampF = ($urandom_range(0, 15) == 0);
      openB = ($urandom_range(0, 15) == 0); adE = ($urandom_range(0, 15) == 0);
      refM = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 5) == 0) begin
        wrEn = 1;
        wrAddr = 3'($urandom_range(0, 7));
        if (wrAddr <= 3'd3) wrData = W'($signed($urandom_range(0, 2400)) - 1200);
        else if (wrAddr == 3'd7)
          wrData = W'({($urandom_range(0, 5) == 0), ($urandom_range(0, 7) != 0)});
        else wrData = W'($urandom_range(0, 255));
      end
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule